// File: doc/BRIEF.md
# Fully-Parallel Small FFT Engine

This block computes a complete fixed-point discrete Fourier transform, forward or inverse, on a power-of-two point count from 2 to 64. Every sample of a transform arrives in the same clock cycle on a bus of 2^SPATIAL_BITS complex lanes. The result leaves on an equally wide bus a fixed number of cycles later. A new transform can enter on every cycle. When the lane count is larger than the point count, the bus is cut into consecutive groups of NPT lanes, and each group is transformed on its own with the same constants.

The datapath is a radix-2 decimation-in-time pipeline. The twiddle multipliers hold constant coefficients, and a butterfly whose twiddle is one has no multiplier at all. Two wiring-only permutations, each chosen by a parameter, let the caller supply samples in natural or bit-reversed order and take results in either order. The inverse transform reuses the same datapath with conjugated coefficients and applies no 1/N scaling. Each butterfly stage widens the word by one bit, so nothing is discarded except the rounding of the twiddle products.

Top module: `par_fft`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly 2*log2(NPT) clock cycles. Results appear in the same cycle as their `out_vld` pulse, and there are no stalls.
- R2: With INVERSE=0, output k of a group is sum over n of x[n]*exp(-j*2*pi*n*k/NPT), with no scaling. For inputs whose real and imaginary parts lie within ±2^(IW-2), each output part is within 4 LSB of the exact value.
- R3: With INVERSE=1, the output uses exp(+j*2*pi*n*k/NPT), again with no 1/NPT scaling and the same accuracy bound as R2.
- R4: Each output lane is IW+log2(NPT) bits, two's complement. An impulse at sample 0 of a group yields that exact sample on every output of the group.
- R5: Lanes g*NPT to g*NPT+NPT-1 form transform g. No group's output depends on any other group's input.
- R6: With IN_REV=1, the lane at position p within a group carries sample x[rev(p)], where rev reverses the log2(NPT) bits of p. With IN_REV=0, the lane at position p carries x[p].
- R7: With OUT_REV=1, the lane at position p within a group carries X[rev(p)]. With OUT_REV=0, it carries X[p].
- R8: While `out_vld` is low, `out_re` and `out_im` keep the last result.
- R9: While reset is active and after it is released, `out_vld` is 0 and both output buses are 0 until the first result arrives.
- R10: Transforms presented on consecutive cycles each come out correct on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Marks the current input bus as one set of transforms |
| in_re | input | IW*2^SPATIAL_BITS | Real parts, lane p at bits p*IW upward |
| in_im | input | IW*2^SPATIAL_BITS | Imaginary parts, same lane layout |
| out_vld | output | 1 | Marks the output bus as holding results |
| out_re | output | (IW+log2 NPT)*2^SPATIAL_BITS | Real parts of results, lane p at bits p*(IW+log2 NPT) upward |
| out_im | output | (IW+log2 NPT)*2^SPATIAL_BITS | Imaginary parts of results, same layout |

## Verification
Every result is due exactly 2*log2(NPT) cycles after the cycle in which its input was accepted. That makes six cycles for the 8-point, 16-lane build and four cycles for the 4-point, 8-lane inverse build that runs beside it. The driver stamps each transform with the cycle count at which it is presented. The monitor pops the expected transform whenever `out_vld` is high and requires the current count to equal that stamp plus the latency, so an early, late or missing result is reported. Output values are sampled on the falling edge. Hold behaviour is checked several idle cycles after the last result.

// File: rtl/pfft_pkg.sv
package pfft_pkg;

  // Quarter-wave cosine table: cos(pi*k/32) scaled by 2^TBL_FRAC, k = 0..16
  localparam int TBL_FRAC = 16;

  function automatic int qcos(input int k);
    case (k)
      0:  return 65536;
      1:  return 65220;
      2:  return 64277;
      3:  return 62714;
      4:  return 60547;
      5:  return 57798;
      6:  return 54491;
      7:  return 50660;
      8:  return 46341;
      9:  return 41576;
      10: return 36410;
      11: return 30893;
      12: return 25080;
      13: return 19024;
      14: return 12785;
      15: return 6424;
      default: return 0;
    endcase
  endfunction

  // Round a table value to frac fractional bits, symmetric around zero
  function automatic int rescale(input int q, input int frac);
    int mag;
    int r;
    mag = (q < 0) ? -q : q;
    if (frac >= TBL_FRAC) r = mag <<< (frac - TBL_FRAC);
    else                  r = (mag + (1 <<< (TBL_FRAC - frac - 1))) >>> (TBL_FRAC - frac);
    return (q < 0) ? -r : r;
  endfunction

  // cos and sin of the angle pi*m/32, m = 0..31
  function automatic int tw_cos(input int m, input int frac);
    return (m <= 16) ? rescale(qcos(m), frac) : rescale(-qcos(32 - m), frac);
  endfunction

  function automatic int tw_sin(input int m, input int frac);
    return (m <= 16) ? rescale(qcos(16 - m), frac) : rescale(qcos(m - 16), frac);
  endfunction

  function automatic int bit_rev(input int v, input int nb);
    int r;
    r = 0;
    for (int i = 0; i < nb; i++) r = r | (((v >>> i) & 1) <<< (nb - 1 - i));
    return r;
  endfunction

endpackage

// File: rtl/pfft_perm.sv
module pfft_perm
  import pfft_pkg::*;
#(
  parameter int W   = 16,
  parameter int NPT = 8,
  parameter int DW  = 12,
  parameter bit EN  = 1'b1
) (
  input  logic [W*DW-1:0] src_re,
  input  logic [W*DW-1:0] src_im,
  output logic [W*DW-1:0] dst_re,
  output logic [W*DW-1:0] dst_im
);

  localparam int LOGN = $clog2(NPT);

  for (genvar p = 0; p < W; p++) begin : g_lane
    localparam int SRC = EN ? ((p / NPT) * NPT + bit_rev(p % NPT, LOGN)) : p;
    assign dst_re[p*DW +: DW] = src_re[SRC*DW +: DW];
    assign dst_im[p*DW +: DW] = src_im[SRC*DW +: DW];
  end

endmodule

// File: rtl/pfft_bfly.sv
module pfft_bfly #(
  parameter int IWS = 12,
  parameter int TW  = 18,
  parameter int TC  = 65536,
  parameter int TS  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_a,
  input  logic                  en_b,
  input  logic signed [IWS-1:0] a_re,
  input  logic signed [IWS-1:0] a_im,
  input  logic signed [IWS-1:0] b_re,
  input  logic signed [IWS-1:0] b_im,
  output logic signed [IWS:0]   s_re,
  output logic signed [IWS:0]   s_im,
  output logic signed [IWS:0]   d_re,
  output logic signed [IWS:0]   d_im
);

  localparam int FR    = TW - 2;
  localparam int PW    = IWS + TW + 1;
  localparam bit UNITY = (TC == (1 <<< FR)) && (TS == 0);

  logic signed [IWS-1:0] ah_re, ah_im;
  logic signed [IWS:0]   tp_re, tp_im, tp_re_nxt, tp_im_nxt;
  logic signed [IWS:0]   s_re_nxt, s_im_nxt, d_re_nxt, d_im_nxt;

  if (UNITY) begin : g_unity
    always_comb begin
      tp_re_nxt = (IWS+1)'(b_re);
      tp_im_nxt = (IWS+1)'(b_im);
    end
  end else begin : g_mult
    localparam logic signed [TW-1:0] KC   = TW'(TC);
    localparam logic signed [TW-1:0] KS   = TW'(TS);
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FR - 1);
    logic signed [PW-1:0] pr, pi;
    always_comb begin
      pr = PW'(b_re) * PW'(KC) - PW'(b_im) * PW'(KS) + HALF;
      pi = PW'(b_re) * PW'(KS) + PW'(b_im) * PW'(KC) + HALF;
      tp_re_nxt = (IWS+1)'(pr >>> FR);
      tp_im_nxt = (IWS+1)'(pi >>> FR);
    end
  end

  always_comb begin
    s_re_nxt = (IWS+1)'(ah_re) + tp_re;
    s_im_nxt = (IWS+1)'(ah_im) + tp_im;
    d_re_nxt = (IWS+1)'(ah_re) - tp_re;
    d_im_nxt = (IWS+1)'(ah_im) - tp_im;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ah_re <= '0;
      ah_im <= '0;
      tp_re <= '0;
      tp_im <= '0;
      s_re  <= '0;
      s_im  <= '0;
      d_re  <= '0;
      d_im  <= '0;
    end else begin
      if (en_a) begin
        ah_re <= a_re;
        ah_im <= a_im;
        tp_re <= tp_re_nxt;
        tp_im <= tp_im_nxt;
      end
      if (en_b) begin
        s_re <= s_re_nxt;
        s_im <= s_im_nxt;
        d_re <= d_re_nxt;
        d_im <= d_im_nxt;
      end
    end
  end

  // R2
  bfly_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(en_a, 2) && $past(en_b))
    |-> (((s_re + d_re) == ((IWS+1)'($past(a_re, 2)) <<< 1)) &&
         ((s_im + d_im) == ((IWS+1)'($past(a_im, 2)) <<< 1))));

  if (UNITY) begin : g_pass_chk
    // R4
    bfly_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(en_a, 2) && $past(en_b))
      |-> (((s_re - d_re) == ((IWS+1)'($past(b_re, 2)) <<< 1)) &&
           ((s_im - d_im) == ((IWS+1)'($past(b_im, 2)) <<< 1))));
  end

endmodule

// File: rtl/pfft_stage.sv
module pfft_stage
  import pfft_pkg::*;
#(
  parameter int W       = 16,
  parameter int NPT     = 8,
  parameter int S       = 0,
  parameter int IWS     = 12,
  parameter int TW      = 18,
  parameter bit INVERSE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vi,
  input  logic [W*IWS-1:0]       xi_re,
  input  logic [W*IWS-1:0]       xi_im,
  output logic                   vo,
  output logic [W*(IWS+1)-1:0]   xo_re,
  output logic [W*(IWS+1)-1:0]   xo_im
);

  localparam int H    = 1 << S;
  localparam int FR   = TW - 2;
  localparam int STEP = 32 / H;
  localparam int OWS  = IWS + 1;

  logic v1, v1_nxt, vo_nxt;

  always_comb begin
    v1_nxt = vi;
    vo_nxt = v1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      vo <= 1'b0;
    end else begin
      v1 <= v1_nxt;
      vo <= vo_nxt;
    end
  end

  for (genvar p = 0; p < W; p++) begin : g_lane
    localparam int LP = p % NPT;
    localparam int RP = LP % (2 * H);
    if (RP < H) begin : g_bf
      localparam int MA  = RP * STEP;
      localparam int TCV = tw_cos(MA, FR);
      localparam int TSV = INVERSE ? tw_sin(MA, FR) : -tw_sin(MA, FR);
      pfft_bfly #(
        .IWS(IWS),
        .TW (TW),
        .TC (TCV),
        .TS (TSV)
      ) u_bf (
        .clk  (clk),
        .rst_n(rst_n),
        .en_a (vi),
        .en_b (v1),
        .a_re (xi_re[p*IWS +: IWS]),
        .a_im (xi_im[p*IWS +: IWS]),
        .b_re (xi_re[(p+H)*IWS +: IWS]),
        .b_im (xi_im[(p+H)*IWS +: IWS]),
        .s_re (xo_re[p*OWS +: OWS]),
        .s_im (xo_im[p*OWS +: OWS]),
        .d_re (xo_re[(p+H)*OWS +: OWS]),
        .d_im (xo_im[(p+H)*OWS +: OWS])
      );
    end
  end

endmodule

// File: rtl/par_fft.sv
module par_fft
  import pfft_pkg::*;
#(
  parameter int NPT          = 8,
  parameter int SPATIAL_BITS = 4,
  parameter int IW           = 12,
  parameter int TW           = 18,
  parameter bit INVERSE      = 1'b0,
  parameter bit IN_REV       = 1'b0,
  parameter bit OUT_REV      = 1'b0
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_vld,
  input  logic [(IW<<SPATIAL_BITS)-1:0]                in_re,
  input  logic [(IW<<SPATIAL_BITS)-1:0]                in_im,
  output logic                                         out_vld,
  output logic [((IW+$clog2(NPT))<<SPATIAL_BITS)-1:0]  out_re,
  output logic [((IW+$clog2(NPT))<<SPATIAL_BITS)-1:0]  out_im
);

  localparam int W    = 1 << SPATIAL_BITS;
  localparam int LOGN = $clog2(NPT);
  localparam int OW   = IW + LOGN;
  localparam int LAT  = 2 * LOGN;

  // Start of stage s input region in the triangular inter-stage bus
  function automatic int boff(input int s);
    return W * (s * IW + (s * (s - 1)) / 2);
  endfunction

  localparam int BUS = boff(LOGN + 1);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs, rs_nxt;
  logic       rst_q;

  always_comb rs_nxt = {rs[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= rs_nxt;
  end

  assign rst_q = rs[1];

  logic [BUS-1:0] bus_re, bus_im;
  logic [LOGN:0]  vb;

  assign vb[0] = in_vld;

  pfft_perm #(
    .W  (W),
    .NPT(NPT),
    .DW (IW),
    .EN (IN_REV == 1'b0)
  ) u_pin (
    .src_re(in_re),
    .src_im(in_im),
    .dst_re(bus_re[boff(0) +: W*IW]),
    .dst_im(bus_im[boff(0) +: W*IW])
  );

  for (genvar s = 0; s < LOGN; s++) begin : g_stage
    pfft_stage #(
      .W      (W),
      .NPT    (NPT),
      .S      (s),
      .IWS    (IW + s),
      .TW     (TW),
      .INVERSE(INVERSE)
    ) u_st (
      .clk  (clk),
      .rst_n(rst_q),
      .vi   (vb[s]),
      .xi_re(bus_re[boff(s) +: W*(IW+s)]),
      .xi_im(bus_im[boff(s) +: W*(IW+s)]),
      .vo   (vb[s+1]),
      .xo_re(bus_re[boff(s+1) +: W*(IW+s+1)]),
      .xo_im(bus_im[boff(s+1) +: W*(IW+s+1)])
    );
  end

  pfft_perm #(
    .W  (W),
    .NPT(NPT),
    .DW (OW),
    .EN (OUT_REV)
  ) u_pout (
    .src_re(bus_re[boff(LOGN) +: W*OW]),
    .src_im(bus_im[boff(LOGN) +: W*OW]),
    .dst_re(out_re),
    .dst_im(out_im)
  );

  assign out_vld = vb[LOGN];

  // R1
  lat_align_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q, LAT) |-> (out_vld == $past(in_vld, LAT)));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!out_vld) |-> ($stable(out_re) && $stable(out_im)));

endmodule

// File: tb/sim_par_fft.sv
`timescale 1ns/1ps
module sim_par_fft;

  localparam int IW   = 12;
  localparam int W0   = 16;
  localparam int N0   = 8;
  localparam int OW0  = 15;
  localparam int LAT0 = 6;
  localparam int W1   = 8;
  localparam int N1   = 4;
  localparam int OW1  = 14;
  localparam int LAT1 = 4;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld;
  logic [W0*IW-1:0]  in_re, in_im;
  logic              o0_vld, o1_vld;
  logic [W0*OW0-1:0] o0_re, o0_im;
  logic [W1*OW1-1:0] o1_re, o1_im;

  always #2.5 clk = ~clk;

  par_fft #(.NPT(N0), .SPATIAL_BITS(4), .IW(IW), .TW(18),
            .INVERSE(1'b0), .IN_REV(1'b0), .OUT_REV(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
    .out_vld(o0_vld), .out_re(o0_re), .out_im(o0_im));

  par_fft #(.NPT(N1), .SPATIAL_BITS(3), .IW(IW), .TW(18),
            .INVERSE(1'b1), .IN_REV(1'b1), .OUT_REV(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_re(in_re[W1*IW-1:0]), .in_im(in_im[W1*IW-1:0]),
    .out_vld(o1_vld), .out_re(o1_re), .out_im(o1_im));

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard storage
  real   e0r [0:63][0:15];
  real   e0i [0:63][0:15];
  real   e1r [0:63][0:7];
  real   e1i [0:63][0:7];
  real   tol_f [0:63];
  int    ts_f  [0:63];
  string tag0  [0:63];
  string tag1  [0:63];
  int    q0[$];
  int    q1[$];
  int    fid = 0;
  int    xr[16];
  int    xi[16];
  int    last0_re[16];
  int    last0_im[16];

  function automatic int rev2(input int p);
    return ((p & 1) << 1) | ((p >> 1) & 1);
  endfunction

  task automatic note(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic send(input string t0, input string t1, input real tol);
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < N0; k++) begin
        real sr, si;
        sr = 0.0; si = 0.0;
        for (int n = 0; n < N0; n++) begin
          real th, c, s, a, b;
          th = 2.0 * PI * real'(n * k) / real'(N0);
          c = $cos(th); s = $sin(th);
          a = real'(xr[g*N0+n]); b = real'(xi[g*N0+n]);
          sr += a * c + b * s;
          si += b * c - a * s;
        end
        e0r[fid][g*N0+k] = sr;
        e0i[fid][g*N0+k] = si;
      end
      for (int p = 0; p < N1; p++) begin
        real sr, si;
        int k;
        k = rev2(p);
        sr = 0.0; si = 0.0;
        for (int n = 0; n < N1; n++) begin
          real th, c, s, a, b;
          th = 2.0 * PI * real'(n * k) / real'(N1);
          c = $cos(th); s = $sin(th);
          a = real'(xr[g*N1+rev2(n)]); b = real'(xi[g*N1+rev2(n)]);
          sr += a * c - b * s;
          si += b * c + a * s;
        end
        e1r[fid][g*N1+p] = sr;
        e1i[fid][g*N1+p] = si;
      end
    end
    for (int p = 0; p < W0; p++) begin
      in_re[p*IW +: IW] = 12'(xr[p]);
      in_im[p*IW +: IW] = 12'(xi[p]);
    end
    in_vld = 1'b1;
    ts_f[fid]  = cyc;
    tol_f[fid] = tol;
    tag0[fid]  = t0;
    tag1[fid]  = t1;
    q0.push_back(fid);
    q1.push_back(fid);
    fid++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_rand();
    for (int p = 0; p < W0; p++) begin
      xr[p] = int'($urandom_range(2047, 0)) - 1024;
      xi[p] = int'($urandom_range(2047, 0)) - 1024;
    end
  endtask

  // Monitor: pops expected transforms as results appear
  always @(negedge clk) begin
    if (rst_n && o0_vld) begin
      if (q0.size() == 0) note(1'b0, "R1 u0 unexpected out_vld: actual 1 expected 0");
      else begin
        int id, bad_p;
        real ar, ai;
        id = q0.pop_front();
        note(cyc == ts_f[id] + LAT0,
             $sformatf("R1 u0 result cycle: actual %0d expected %0d", cyc, ts_f[id] + LAT0));
        bad_p = -1;
        for (int p = 0; p < W0; p++) begin
          last0_re[p] = int'($signed(o0_re[p*OW0 +: OW0]));
          last0_im[p] = int'($signed(o0_im[p*OW0 +: OW0]));
          ar = real'(last0_re[p]); ai = real'(last0_im[p]);
          if (bad_p < 0 && ((ar - e0r[id][p] > tol_f[id] + 0.001) || (e0r[id][p] - ar > tol_f[id] + 0.001) ||
                            (ai - e0i[id][p] > tol_f[id] + 0.001) || (e0i[id][p] - ai > tol_f[id] + 0.001)))
            bad_p = p;
        end
        if (bad_p < 0) note(1'b1, "");
        else note(1'b0, $sformatf("%s u0 lane %0d: actual (%0d,%0d) expected (%f,%f)", tag0[id], bad_p,
                  last0_re[bad_p], last0_im[bad_p], e0r[id][bad_p], e0i[id][bad_p]));
      end
    end
    if (rst_n && o1_vld) begin
      if (q1.size() == 0) note(1'b0, "R1 u1 unexpected out_vld: actual 1 expected 0");
      else begin
        int id, bad_p, vr[8], vi[8];
        real ar, ai;
        id = q1.pop_front();
        note(cyc == ts_f[id] + LAT1,
             $sformatf("R1 u1 result cycle: actual %0d expected %0d", cyc, ts_f[id] + LAT1));
        bad_p = -1;
        for (int p = 0; p < W1; p++) begin
          vr[p] = int'($signed(o1_re[p*OW1 +: OW1]));
          vi[p] = int'($signed(o1_im[p*OW1 +: OW1]));
          ar = real'(vr[p]); ai = real'(vi[p]);
          if (bad_p < 0 && ((ar - e1r[id][p] > tol_f[id] + 0.001) || (e1r[id][p] - ar > tol_f[id] + 0.001) ||
                            (ai - e1i[id][p] > tol_f[id] + 0.001) || (e1i[id][p] - ai > tol_f[id] + 0.001)))
            bad_p = p;
        end
        if (bad_p < 0) note(1'b1, "");
        else note(1'b0, $sformatf("%s u1 lane %0d: actual (%0d,%0d) expected (%f,%f)", tag1[id], bad_p,
                  vr[bad_p], vi[bad_p], e1r[id][bad_p], e1i[id][bad_p]));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_re  = '0;
    in_im  = '0;
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    note(!o0_vld && !o1_vld, $sformatf("R9 out_vld in reset: actual %0b%0b expected 00", o0_vld, o1_vld));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: state after release
    note(!o0_vld && o0_re == '0 && o0_im == '0 && o1_re == '0 && o1_im == '0,
         $sformatf("R9 after reset: actual vld %0b re %0h expected vld 0 re 0", o0_vld, o0_re));

    // R4: impulse at sample 0 of each group, exact
    for (int p = 0; p < W0; p++) begin xr[p] = 0; xi[p] = 0; end
    xr[0] = 500;  xi[0] = -300;
    xr[4] = 0;
    xr[8] = -700; xi[8] = 200;
    send("R4", "R4", 0.0);
    idle(8);

    // R2: constant input
    for (int p = 0; p < W0; p++) begin xr[p] = 100; xi[p] = 50; end
    send("R2", "R3 R6 R7", 4.0);
    idle(2);

    // R2: single tones, bin 1 in group 0, bin 3 in group 1
    for (int p = 0; p < W0; p++) begin
      real th;
      th = 2.0 * PI * real'((p % 8) * ((p < 8) ? 1 : 3)) / 8.0;
      xr[p] = $rtoi(900.0 * $cos(th));
      xi[p] = $rtoi(900.0 * $sin(th));
    end
    send("R2", "R3 R6 R7", 4.0);
    idle(1);

    // R10: back-to-back transforms
    for (int f = 0; f < 3; f++) begin
      fill_rand();
      send("R10", "R10", 4.0);
    end
    idle(3);

    // R5: group 0 silent, group 1 active
    fill_rand();
    for (int p = 0; p < 8; p++) begin xr[p] = 0; xi[p] = 0; end
    send("R5", "R5", 4.0);
    idle(2);

    // R2 and R3 with R6 R7: further random frames with gaps
    fill_rand();
    send("R2", "R3 R6 R7", 4.0);
    idle(5);
    fill_rand();
    send("R2", "R3 R6 R7", 4.0);
    idle(12);

    // R8: outputs keep last result while out_vld is low
    begin
      int bad_p;
      bad_p = -1;
      for (int p = 0; p < W0; p++)
        if (bad_p < 0 && (int'($signed(o0_re[p*OW0 +: OW0])) != last0_re[p] ||
                          int'($signed(o0_im[p*OW0 +: OW0])) != last0_im[p]))
          bad_p = p;
      note(!o0_vld && bad_p < 0,
           $sformatf("R8 hold lane %0d: actual (%0d,%0d) expected (%0d,%0d)", bad_p,
                     (bad_p < 0) ? 0 : int'($signed(o0_re[bad_p*OW0 +: OW0])),
                     (bad_p < 0) ? 0 : int'($signed(o0_im[bad_p*OW0 +: OW0])),
                     (bad_p < 0) ? 0 : last0_re[bad_p], (bad_p < 0) ? 0 : last0_im[bad_p]));
    end

    // R1: every presented transform produced a result
    note(q0.size() == 0, $sformatf("R1 u0 missing results: actual %0d expected 0", q0.size()));
    note(q1.size() == 0, $sformatf("R1 u1 missing results: actual %0d expected 0", q1.size()));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule